// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Status

This block keeps the interrupt and status state of a two-channel serial controller. For each channel it holds a receive-pending flag and a transmit-pending flag, a latched received byte, and a small set of status read registers. A host reaches the block through a byte-wide register port: a channel select, a data/control select and a register index. A per-channel strobe delivers each received byte. One shared interrupt output combines the flags of both channels. Each channel's enable bits gate its own flags onto that output.

The pending flags of both channels are visible in one place only: pending register 3 of channel A. The same register on channel B reads as zero. Command codes written to control register 0 clear the receive flag, the transmit flag or both. Reading the receive data register consumes the byte and clears the receive flag. Writing the transmit data register marks the transmitter empty and raises the transmit flag. Serialization, baud timing and modem lines belong elsewhere.

Each channel's flags live in a four-state machine. The states are `CH_QUIET` (no flag), `CH_RX_PEND` (receive only), `CH_TX_PEND` (transmit only) and `CH_BOTH_PEND` (both flags). The transitions are:
- byte arrival: QUIET→RX_PEND and TX_PEND→BOTH_PEND.
- transmit write: QUIET→TX_PEND and RX_PEND→BOTH_PEND.
- receive clear, by command 0x20 or 0x38 or by a data read: RX_PEND→QUIET and BOTH_PEND→TX_PEND.
- transmit clear, by command 0x28 or 0x38: TX_PEND→QUIET and BOTH_PEND→RX_PEND.
- both clear, by command 0x38: BOTH_PEND→QUIET.

Every state holds when none of these events occurs.

Top module: `ser_dual_irq_stat`

## Requirements
- R1: While reset is asserted and after it is released, every flag, status bit, enable and latched byte is zero. `irq` is low and `bus_rdata` is zero.
- R2: A write to the transmit data register (`bus_dsel`=1) of a channel has three effects on that channel. It sets status register 0 bit 2 (transmitter empty), sets status register 1 bit 0 (all sent), and sets the transmit flag.
- R3: A pulse on `rx_strobe[c]` has three effects on channel c. It latches the channel's input byte, sets status register 0 bit 0 (byte available), and sets the receive flag.
- R4: A read of the receive data register returns the latched byte. It also clears status register 0 bit 0 and the receive flag of that channel.
- R5: Register index 3 of channel A reads as follows: bit 5 is the A receive flag, bit 4 the A transmit flag, bit 2 the B receive flag, bit 1 the B transmit flag, and all other bits are 0. Index 3 of channel B reads 0.
- R6: A write to control index 0 is a command. Code 0x20 clears the receive flag, 0x28 clears the transmit flag and 0x38 clears both. No other code changes any flag, and no command changes status register 0 bit 0.
- R7: `irq` is high exactly when some channel has its receive flag set together with enable bit 0, or its transmit flag set together with enable bit 1. The enable bits live in control index 1. Writing the enables does not change any flag.
- R8: When a byte strobe arrives in the same cycle as a data read or a receive-clear command on that channel, the strobe wins. The flag and the available bit stay set, the new byte is latched, and the read returns the previous byte.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and is 0 in every cycle that follows no read. Indices other than 0, 1 and 3 read 0. When `bus_wr` and `bus_rd` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_ch | input | 1 | Channel select, 0 = A, 1 = B |
| bus_dsel | input | 1 | 1 selects the data register, 0 a control/status index |
| bus_idx | input | IDX_W | Control/status register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_strobe | input | 2 | Received-byte strobe per channel (bit 0 = A) |
| rx_byte_a | input | DATA_W | Received byte for channel A |
| rx_byte_b | input | DATA_W | Received byte for channel B |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest situation to reach is a collision on one channel: a byte strobe in the same cycle as a read of that channel's data register or a receive-clear command. The bus alone can never produce it. The stimulus lines up the strobe with the read or the command on one edge in directed steps. It then runs a long random phase in which strobes, commands and reads on both channels overlap freely. A behavioural model predicts `bus_rdata` and `irq` on every cycle.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    // control register indices
    localparam int unsigned IDX_CMD    = 0;
    localparam int unsigned IDX_ENA    = 1;
    // status register indices
    localparam int unsigned IDX_STAT0  = 0;
    localparam int unsigned IDX_STAT1  = 1;
    localparam int unsigned IDX_PEND   = 3;

    // command codes
    localparam logic [7:0] CMD_CLR_RX   = 8'h20;
    localparam logic [7:0] CMD_CLR_TX   = 8'h28;
    localparam logic [7:0] CMD_CLR_BOTH = 8'h38;

    // bit positions
    localparam int unsigned B_AVAIL    = 0;  // status 0
    localparam int unsigned B_TEMPTY   = 2;  // status 0
    localparam int unsigned B_ALLSENT  = 0;  // status 1
    localparam int unsigned B_A_RX     = 5;  // pending
    localparam int unsigned B_A_TX     = 4;
    localparam int unsigned B_B_RX     = 2;
    localparam int unsigned B_B_TX     = 1;
    localparam int unsigned B_EN_RX    = 0;  // enable register
    localparam int unsigned B_EN_TX    = 1;

    typedef enum logic [1:0] {
        CH_QUIET     = 2'd0,
        CH_RX_PEND   = 2'd1,
        CH_TX_PEND   = 2'd2,
        CH_BOTH_PEND = 2'd3
    } chan_state_e;

endpackage

// File: rtl/ser_chan_ctl.sv
module ser_chan_ctl
    import ser_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              data_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pend,
    output logic              tx_pend,
    output logic              en_rx,
    output logic              en_tx,
    output logic [DATA_W-1:0] stat0,
    output logic [DATA_W-1:0] stat1,
    output logic [DATA_W-1:0] rx_hold
);

    chan_state_e state_q, state_d;

    logic              avail_q, tempty_q, allsent_q;
    logic [1:0]        ena_q;
    logic [DATA_W-1:0] hold_q;

    logic cmd_wr, ena_wr, tx_wr, data_rd;
    logic clr_rx, clr_tx;
    logic rx_cur, tx_cur, rx_nxt, tx_nxt;

    // event decode
    always_comb begin
        cmd_wr  = wr_stb && !data_sel && (idx == IDX_W'(IDX_CMD));
        ena_wr  = wr_stb && !data_sel && (idx == IDX_W'(IDX_ENA));
        tx_wr   = wr_stb && data_sel;
        data_rd = rd_stb && data_sel;
        clr_rx  = data_rd ||
                  (cmd_wr && ((wdata[7:0] == CMD_CLR_RX) || (wdata[7:0] == CMD_CLR_BOTH)));
        clr_tx  = cmd_wr && ((wdata[7:0] == CMD_CLR_TX) || (wdata[7:0] == CMD_CLR_BOTH));
    end

    // next-state: set beats clear
    always_comb begin
        rx_cur = 1'b0;
        tx_cur = 1'b0;
        unique case (state_q)
            CH_QUIET:     begin rx_cur = 1'b0; tx_cur = 1'b0; end
            CH_RX_PEND:   begin rx_cur = 1'b1; tx_cur = 1'b0; end
            CH_TX_PEND:   begin rx_cur = 1'b0; tx_cur = 1'b1; end
            CH_BOTH_PEND: begin rx_cur = 1'b1; tx_cur = 1'b1; end
        endcase
        rx_nxt = rx_stb || (rx_cur && !clr_rx);
        tx_nxt = tx_wr  || (tx_cur && !clr_tx);
        unique case ({rx_nxt, tx_nxt})
            2'b00: state_d = CH_QUIET;
            2'b10: state_d = CH_RX_PEND;
            2'b01: state_d = CH_TX_PEND;
            2'b11: state_d = CH_BOTH_PEND;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_d;
    end

    // status and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avail_q   <= 1'b0;
            tempty_q  <= 1'b0;
            allsent_q <= 1'b0;
            ena_q     <= 2'b00;
            hold_q    <= '0;
        end else begin
            if (tx_wr) begin
                tempty_q  <= 1'b1;
                allsent_q <= 1'b1;
            end
            if (ena_wr) ena_q <= {wdata[B_EN_TX], wdata[B_EN_RX]};
            if (rx_stb) begin
                hold_q  <= rx_data;
                avail_q <= 1'b1;
            end else if (data_rd) begin
                avail_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        rx_pend = 1'b0;
        tx_pend = 1'b0;
        unique case (state_q)
            CH_QUIET:     ;
            CH_RX_PEND:   rx_pend = 1'b1;
            CH_TX_PEND:   tx_pend = 1'b1;
            CH_BOTH_PEND: begin rx_pend = 1'b1; tx_pend = 1'b1; end
        endcase
        stat0            = '0;
        stat0[B_AVAIL]   = avail_q;
        stat0[B_TEMPTY]  = tempty_q;
        stat1            = '0;
        stat1[B_ALLSENT] = allsent_q;
        en_rx            = ena_q[0];
        en_tx            = ena_q[1];
        rx_hold          = hold_q;
    end

    // R3
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> (rx_pend && stat0[B_AVAIL]));

    // R2
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (tx_pend && stat0[B_TEMPTY] && stat1[B_ALLSENT]));

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_stb) |=> (!rx_pend && !stat0[B_AVAIL]));

    // R6
    cmd_tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tx |=> !tx_pend);

    // R6
    cmd_keeps_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !rx_stb) |=> $stable(stat0[B_AVAIL]));

    // R7
    ena_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_wr && !rx_stb) |=> (rx_pend == $past(rx_pend) && tx_pend == $past(tx_pend)));

endmodule

// File: rtl/ser_irq_status.sv
module ser_irq_status
    import ser_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_pend,
    input  logic [1:0]        tx_pend,
    input  logic [1:0]        en_rx,
    input  logic [1:0]        en_tx,
    output logic [DATA_W-1:0] pend_vec,
    output logic              irq
);

    always_comb begin
        pend_vec         = '0;
        pend_vec[B_A_RX] = rx_pend[0];
        pend_vec[B_A_TX] = tx_pend[0];
        pend_vec[B_B_RX] = rx_pend[1];
        pend_vec[B_B_TX] = tx_pend[1];
        irq = |((rx_pend & en_rx) | (tx_pend & en_tx));
    end

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0) |-> !irq);

    // R5
    pend_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_vec) == $countones({rx_pend, tx_pend}));

endmodule

// File: rtl/ser_dual_irq_stat.sv
module ser_dual_irq_stat
    import ser_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ch,
    input  logic              bus_dsel,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        rx_strobe,
    input  logic [DATA_W-1:0] rx_byte_a,
    input  logic [DATA_W-1:0] rx_byte_b,
    output logic              irq
);

    localparam int unsigned NUM_CH = 2;

    logic [1:0]        rx_pend, tx_pend, en_rx, en_tx;
    logic [DATA_W-1:0] stat0   [NUM_CH];
    logic [DATA_W-1:0] stat1   [NUM_CH];
    logic [DATA_W-1:0] hold    [NUM_CH];
    logic [DATA_W-1:0] rx_in   [NUM_CH];
    logic [DATA_W-1:0] pend_vec;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_ok;

    assign rx_in[0] = rx_byte_a;
    assign rx_in[1] = rx_byte_b;
    assign rd_ok    = bus_rd && !bus_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ser_chan_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (bus_wr && (bus_ch == 1'(c))),
            .rd_stb   (rd_ok  && (bus_ch == 1'(c))),
            .data_sel (bus_dsel),
            .idx      (bus_idx),
            .wdata    (bus_wdata),
            .rx_stb   (rx_strobe[c]),
            .rx_data  (rx_in[c]),
            .rx_pend  (rx_pend[c]),
            .tx_pend  (tx_pend[c]),
            .en_rx    (en_rx[c]),
            .en_tx    (en_tx[c]),
            .stat0    (stat0[c]),
            .stat1    (stat1[c]),
            .rx_hold  (hold[c])
        );
    end

    ser_irq_status #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pend  (rx_pend),
        .tx_pend  (tx_pend),
        .en_rx    (en_rx),
        .en_tx    (en_tx),
        .pend_vec (pend_vec),
        .irq      (irq)
    );

    // read mux
    always_comb begin
        rd_sel = '0;
        if (bus_dsel) begin
            rd_sel = hold[bus_ch];
        end else begin
            case (bus_idx)
                IDX_W'(IDX_STAT0): rd_sel = stat0[bus_ch];
                IDX_W'(IDX_STAT1): rd_sel = stat1[bus_ch];
                IDX_W'(IDX_PEND):  rd_sel = bus_ch ? '0 : pend_vec;
                default:           rd_sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_ok) rdata_q <= rd_sel;
        else            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    // R9
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (bus_rdata == '0));

    // R5
    b_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && bus_ch && !bus_dsel && bus_idx == IDX_W'(IDX_PEND)) |=> (bus_rdata == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!irq && bus_rdata == '0));

endmodule

// File: tb/sim_ser_dual_irq_stat.sv
module sim_ser_dual_irq_stat;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 0, bus_rd = 0, bus_ch = 0, bus_dsel = 0;
    logic [3:0] bus_idx = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [1:0] rx_strobe = 0;
    logic [7:0] rx_byte_a = 0, rx_byte_b = 0;
    logic       irq;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    ser_dual_irq_stat u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ch(bus_ch),
        .bus_dsel(bus_dsel), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_strobe(rx_strobe), .rx_byte_a(rx_byte_a),
        .rx_byte_b(rx_byte_b), .irq(irq)
    );

    // behavioural reference model
    bit         m_rx[2], m_tx[2], m_av[2], m_te[2], m_as[2], m_erx[2], m_etx[2];
    logic [7:0] m_hold[2];
    logic [7:0] m_rdata = 0;

    function automatic bit model_irq();
        bit r = 0;
        for (int c = 0; c < 2; c++)
            r |= (m_rx[c] && m_erx[c]) || (m_tx[c] && m_etx[c]);
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_rx[c] = 0; m_tx[c] = 0; m_av[c] = 0; m_te[c] = 0; m_as[c] = 0;
                m_erx[c] = 0; m_etx[c] = 0; m_hold[c] = 0;
            end
            m_rdata = 0;
        end else begin
            automatic logic [7:0] nr = 0;
            automatic int c = bus_ch;
            automatic bit do_rd = bus_rd && !bus_wr;
            if (do_rd) begin
                if (bus_dsel) nr = m_hold[c];
                else if (bus_idx == 0) nr = {5'd0, m_te[c], 1'b0, m_av[c]};
                else if (bus_idx == 1) nr = {7'd0, m_as[c]};
                else if (bus_idx == 3 && c == 0)
                    nr = {2'b0, m_rx[0], m_tx[0], 1'b0, m_rx[1], m_tx[1], 1'b0};
            end
            if (bus_wr) begin
                if (bus_dsel) begin m_te[c] = 1; m_as[c] = 1; m_tx[c] = 1; end
                else if (bus_idx == 0) begin
                    if (bus_wdata == 8'h20 || bus_wdata == 8'h38) m_rx[c] = 0;
                    if (bus_wdata == 8'h28 || bus_wdata == 8'h38) m_tx[c] = 0;
                end else if (bus_idx == 1) begin
                    m_erx[c] = bus_wdata[0]; m_etx[c] = bus_wdata[1];
                end
            end
            if (do_rd && bus_dsel) begin m_av[c] = 0; m_rx[c] = 0; end
            if (rx_strobe[0]) begin m_hold[0] = rx_byte_a; m_av[0] = 1; m_rx[0] = 1; end
            if (rx_strobe[1]) begin m_hold[1] = rx_byte_b; m_av[1] = 1; m_rx[1] = 1; end
            m_rdata = nr;
        end
    end

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "rdata", bus_rdata, m_rdata);
            check(cur_req, "irq", {7'd0, irq}, {7'd0, model_irq()});
        end
    end

    task automatic op(bit wr, bit rd, bit ch, bit ds, int idx, logic [7:0] wd,
                      logic [1:0] stb = 0, logic [7:0] ba = 0, logic [7:0] bb = 0);
        bus_wr = wr; bus_rd = rd; bus_ch = ch; bus_dsel = ds; bus_idx = 4'(idx);
        bus_wdata = wd; rx_strobe = stb; rx_byte_a = ba; rx_byte_b = bb;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_strobe = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #4000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1;
        op(0, 1, 0, 0, 3, 0); idle(1);                 // R1 pending reads zero
        op(0, 1, 1, 0, 0, 0); idle(1);

        cur_req = "R2";
        op(1, 0, 0, 1, 0, 8'h41);
        op(0, 1, 0, 0, 0, 0); op(0, 1, 0, 0, 1, 0); idle(1);
        op(1, 0, 1, 1, 0, 8'h42);
        op(0, 1, 1, 0, 0, 0); op(0, 1, 1, 0, 1, 0); idle(1);

        cur_req = "R5";
        op(0, 1, 0, 0, 3, 0); op(0, 1, 1, 0, 3, 0); idle(1);

        cur_req = "R3";
        op(0, 0, 0, 0, 0, 0, 2'b01, 8'h5A, 0);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 2'b10, 0, 8'hC3);
        op(0, 1, 0, 0, 3, 0); idle(1);

        cur_req = "R4";
        op(0, 1, 0, 1, 0, 0); op(0, 1, 0, 0, 0, 0); op(0, 1, 0, 0, 3, 0);
        op(0, 1, 1, 1, 0, 0); op(0, 1, 0, 0, 3, 0); idle(1);

        cur_req = "R6";
        op(0, 0, 0, 0, 0, 0, 2'b11, 8'h11, 8'h22);
        op(1, 0, 0, 0, 0, 8'h10); op(0, 1, 0, 0, 3, 0);   // no-effect code
        op(1, 0, 0, 0, 0, 8'h20); op(0, 1, 0, 0, 3, 0); op(0, 1, 0, 0, 0, 0);
        op(1, 0, 1, 0, 0, 8'h28); op(0, 1, 0, 0, 3, 0);
        op(1, 0, 0, 0, 0, 8'h38); op(1, 0, 1, 0, 0, 8'h38); op(0, 1, 0, 0, 3, 0);
        idle(1);

        cur_req = "R7";
        op(1, 0, 1, 0, 1, 8'h01); idle(1);
        op(0, 0, 0, 0, 0, 0, 2'b10, 0, 8'h7E); idle(1);
        op(1, 0, 1, 0, 1, 8'h02); idle(1);
        op(1, 0, 1, 1, 0, 8'h00); idle(1);
        op(1, 0, 0, 0, 1, 8'h03); op(1, 0, 1, 0, 1, 8'h00); idle(1);
        op(1, 0, 0, 1, 0, 8'h00); idle(1);
        op(1, 0, 0, 0, 0, 8'h38); op(0, 1, 0, 0, 3, 0); idle(1);

        cur_req = "R8";
        op(1, 0, 0, 0, 1, 8'h03);
        op(0, 0, 0, 0, 0, 0, 2'b01, 8'hA1, 0);
        op(0, 1, 0, 1, 0, 0, 2'b01, 8'hB2, 0);           // read+strobe
        op(0, 1, 0, 0, 0, 0);
        op(1, 0, 0, 0, 0, 8'h20, 2'b01, 8'hC4, 0);       // clear+strobe
        op(0, 1, 0, 0, 3, 0); op(0, 1, 0, 1, 0, 0); idle(1);

        cur_req = "R9";
        op(0, 1, 0, 0, 2, 0); op(0, 1, 0, 0, 7, 0); idle(1);
        op(0, 0, 0, 0, 0, 0, 2'b01, 8'h66, 0);
        op(1, 1, 0, 1, 0, 8'h00); idle(1);                // write only, byte kept
        op(0, 1, 0, 0, 0, 0); op(0, 1, 0, 1, 0, 0); idle(1);

        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            automatic int k = $urandom_range(0, 3);
            automatic logic [7:0] wd;
            case ($urandom_range(0, 4))
                0: wd = 8'h20; 1: wd = 8'h28; 2: wd = 8'h38; 3: wd = 8'h10;
                default: wd = 8'($urandom_range(0, 3));
            endcase
            op(($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               (k == 2) ? 3 : k, wd, 2'($urandom_range(0, 3)),
               8'($urandom), 8'($urandom));
        end
        idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule